// File: doc/BRIEF.md
# Dual Capture/Match Channel Event Unit

This block is the event engine of one timer channel. Two match registers are compared against two free-running time bases: slot A watches time base A and slot B watches time base B. When a comparator fires, the block records the current time base in the capture register of that slot. It sets a sticky match flag and applies a programmable action to the channel output pin. Each comparator works in one of two modes. In greater-or-equal mode the comparison is wrap-aware. In equal-only mode it fires on an exact hit.

Qualified edges on the channel input pin also fill the capture registers. In single-action mode every qualified edge goes to slot A. In double-action mode the first edge goes to slot A and the second to slot B, which lets one channel measure both edges of a pulse. Double-action mode also chains the comparators, so match B is armed only by the firing of match A.

A link request from another channel or a service request from the host sets a flag of its own. Any set flag raises the service request output. All controls are plain strobes and level inputs, sampled on every rising clock edge. Nothing at the block's edge waits, so there is no back-pressure. Flags are cleared by writing ones.

Top module: `chan_event_unit`

## Requirements
- R1: While reset is held, `cap_a`, `cap_b`, `flags`, `srv_req` and `pin_out` are zero. Both comparators come out of reset disarmed, so they never fire until their match register is written, even when the time base equals the reset match value.
- R2: In greater-or-equal mode (`cfg_ge_*`=1) an armed comparator fires when (time base − match) mod 2^24 is below 2^23. This holds across the 24-bit wrap. A difference of exactly 2^23 does not fire.
- R3: In equal-only mode (`cfg_ge_*`=0) an armed comparator fires only in a cycle where its time base equals the match value exactly. Stepping over the value does not fire it.
- R4: A comparator that is armed and hits in a cycle fires at the next rising edge. At that edge its time base value is copied into its capture register (A to `cap_a`, B to `cap_b`), and its match flag is set (`flags[0]` for A, `flags[1]` for B).
- R5: After firing, a comparator disarms. It fires again only after its match register is written.
- R6: A write to match A always arms it. A write to match B arms it in single-action mode (`cfg_double`=0). In double-action mode (`cfg_double`=1) a write to match B only stores the value, and match B is armed by the firing of match A.
- R7: `act_a`/`act_b` choose the pin action on a fire: 0 leaves the pin, 1 drives it high, 2 drives it low, 3 toggles it. `pin_out` changes at the firing edge. When both slots fire at the same edge, A's action is applied first and B's action is applied to its result.
- R8: Each `flag_clr` bit that is one clears the matching `flags` bit. A flag being set at the same edge stays set. The flag positions are: 0 match A, 1 match B, 2 edge A, 3 edge B, 4 link, 5 host.
- R9: `cfg_edge` selects the qualified input edges: 0 none, 1 rising, 2 falling, 3 both. An edge is seen when `pin_in` differs from its value at the previous edge. In single-action mode each qualified edge copies time base A into `cap_a` and sets `flags[2]`.
- R10: In double-action mode the first qualified edge goes to slot A (`flags[2]` clear). The next edge goes to slot B, which copies time base B into `cap_b` and sets `flags[3]`. Further edges are dropped until the flags are cleared.
- R11: If a match fire and an edge target the same slot at the same edge, the match wins. The capture holds the match time and the edge flag is not set.
- R12: A one-cycle `link_req` sets `flags[4]` and a one-cycle `host_req` sets `flags[5]`. `srv_req` is high exactly when any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_a | input | 24 | Time base watched by slot A |
| tb_b | input | 24 | Time base watched by slot B |
| wr_data | input | 24 | Value for match register writes |
| wr_match_a | input | 1 | Write strobe for match A |
| wr_match_b | input | 1 | Write strobe for match B |
| cfg_double | input | 1 | 1 selects double-action mode |
| cfg_ge_a | input | 1 | 1 selects greater-or-equal for A, 0 equal-only |
| cfg_ge_b | input | 1 | 1 selects greater-or-equal for B, 0 equal-only |
| act_a | input | 2 | Pin action on a match A fire |
| act_b | input | 2 | Pin action on a match B fire |
| cfg_edge | input | 2 | Qualified input edges |
| pin_in | input | 1 | Channel input pin, synchronous |
| link_req | input | 1 | Link request pulse from another channel |
| host_req | input | 1 | Service request pulse from the host |
| flag_clr | input | 6 | Write-one-to-clear for the flags |
| cap_a | output | 24 | Capture register A |
| cap_b | output | 24 | Capture register B |
| flags | output | 6 | Sticky event flags |
| srv_req | output | 1 | Service request, OR of the flags |
| pin_out | output | 1 | Channel output pin |

## Verification
The bench drives the comparison through the 24-bit wrap and onto the exact half-range boundary. A comparator that compares plainly would miss the wrapped match, and one with an off-by-one threshold would fire at 2^23. It steps time bases over an equal-only match value, which a comparator stuck in greater-or-equal mode would fire on. It writes match B early in double-action mode, which a design with no chaining would fire at once. It also makes both slots fire together with actions that differ by order: applying B's action before A's leaves the pin high instead of low. Finally, it lands an edge on the same edge as a match, a third edge in double mode, and a flag clear on the same edge as a link request. These catch a swapped priority, an overwritten capture and a lost flag.

// File: rtl/evu_pkg.sv
package evu_pkg;
  localparam int NSLOT = 2;
  localparam int NFLAG = 6;
  localparam int FL_MA = 0;
  localparam int FL_MB = 1;
  localparam int FL_EA = 2;
  localparam int FL_EB = 3;
  localparam int FL_LNK = 4;
  localparam int FL_HST = 5;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_HIGH   = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_TOGGLE = 2'd3
  } pin_act_e;

  function automatic logic apply_act(input logic [1:0] act, input logic cur);
    case (pin_act_e'(act))
      ACT_HIGH:   return 1'b1;
      ACT_LOW:    return 1'b0;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/evu_match_cmp.sv
module evu_match_cmp #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tbase,
  input  logic          wr,
  input  logic [TW-1:0] wdata,
  input  logic          arm_on_wr,
  input  logic          arm_ext,
  input  logic          ge_mode,
  output logic [TW-1:0] match_q,
  output logic          armed,
  output logic          fire
);
  logic [TW-1:0] diff;
  logic          hit;

  // wrap-aware: difference in the lower half of the ring means "reached"
  always_comb begin
    diff = tbase - match_q;
    hit  = ge_mode ? ~diff[TW-1] : (tbase == match_q);
    fire = armed & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      armed   <= 1'b0;
    end else begin
      if (wr) match_q <= wdata;
      if (wr)           armed <= arm_on_wr;
      else if (arm_ext) armed <= 1'b1;
      else if (fire)    armed <= 1'b0;
    end
  end
endmodule

// File: rtl/evu_edge_det.sv
module evu_edge_det (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic [1:0] cfg_edge,
  output logic       qual
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_in;
  end

  always_comb begin
    qual = (pin_in & ~pin_q & cfg_edge[0]) | (~pin_in & pin_q & cfg_edge[1]);
  end
endmodule

// File: rtl/evu_pin_ctrl.sv
module evu_pin_ctrl
  import evu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire_a,
  input  logic       fire_b,
  input  logic [1:0] act_a,
  input  logic [1:0] act_b,
  output logic       pin_out
);
  logic after_a, after_b;

  // slot A first, slot B applied on top
  always_comb begin
    after_a = fire_a ? apply_act(act_a, pin_out) : pin_out;
    after_b = fire_b ? apply_act(act_b, after_a) : after_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_out <= 1'b0;
    else        pin_out <= after_b;
  end
endmodule

// File: rtl/chan_event_unit.sv
module chan_event_unit
  import evu_pkg::*;
#(
  parameter int TW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    tb_a,
  input  logic [TW-1:0]    tb_b,
  input  logic [TW-1:0]    wr_data,
  input  logic             wr_match_a,
  input  logic             wr_match_b,
  input  logic             cfg_double,
  input  logic             cfg_ge_a,
  input  logic             cfg_ge_b,
  input  logic [1:0]       act_a,
  input  logic [1:0]       act_b,
  input  logic [1:0]       cfg_edge,
  input  logic             pin_in,
  input  logic             link_req,
  input  logic             host_req,
  input  logic [NFLAG-1:0] flag_clr,
  output logic [TW-1:0]    cap_a,
  output logic [TW-1:0]    cap_b,
  output logic [NFLAG-1:0] flags,
  output logic             srv_req,
  output logic             pin_out
);
  logic [TW-1:0] tb_v    [NSLOT];
  logic [TW-1:0] match_v [NSLOT];
  logic          wr_v    [NSLOT];
  logic          ge_v    [NSLOT];
  logic          arm_wr_v[NSLOT];
  logic          arm_ex_v[NSLOT];
  logic          armed_v [NSLOT];
  logic          fire_v  [NSLOT];

  logic          fire_a, fire_b, armed_a, armed_b;
  logic [TW-1:0] match_a;
  logic          edge_q, to_a, to_b;
  logic [NFLAG-1:0] set_v;

  always_comb begin
    tb_v[0]     = tb_a;
    tb_v[1]     = tb_b;
    wr_v[0]     = wr_match_a;
    wr_v[1]     = wr_match_b;
    ge_v[0]     = cfg_ge_a;
    ge_v[1]     = cfg_ge_b;
    arm_wr_v[0] = 1'b1;
    arm_wr_v[1] = ~cfg_double;
    arm_ex_v[0] = 1'b0;
    arm_ex_v[1] = cfg_double & fire_v[0];
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
    evu_match_cmp #(.TW(TW)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tbase     (tb_v[g]),
      .wr        (wr_v[g]),
      .wdata     (wr_data),
      .arm_on_wr (arm_wr_v[g]),
      .arm_ext   (arm_ex_v[g]),
      .ge_mode   (ge_v[g]),
      .match_q   (match_v[g]),
      .armed     (armed_v[g]),
      .fire      (fire_v[g])
    );
  end

  always_comb begin
    fire_a  = fire_v[0];
    fire_b  = fire_v[1];
    armed_a = armed_v[0];
    armed_b = armed_v[1];
    match_a = match_v[0];
  end

  evu_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .cfg_edge (cfg_edge),
    .qual     (edge_q)
  );

  evu_pin_ctrl u_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_a  (fire_a),
    .fire_b  (fire_b),
    .act_a   (act_a),
    .act_b   (act_b),
    .pin_out (pin_out)
  );

  // edge steering: slot A unless double mode already holds an A edge
  always_comb begin
    to_a = edge_q & (~cfg_double | ~flags[FL_EA]);
    to_b = edge_q & cfg_double & flags[FL_EA] & ~flags[FL_EB];
    set_v          = '0;
    set_v[FL_MA]   = fire_a;
    set_v[FL_MB]   = fire_b;
    set_v[FL_EA]   = to_a & ~fire_a;
    set_v[FL_EB]   = to_b & ~fire_b;
    set_v[FL_LNK]  = link_req;
    set_v[FL_HST]  = host_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
      flags <= '0;
    end else begin
      if (fire_a || to_a) cap_a <= tb_a;
      if (fire_b || to_b) cap_b <= tb_b;
      flags <= (flags & ~flag_clr) | set_v;
    end
  end

  always_comb srv_req = |flags;
endmodule

// File: rtl/evu_checker.sv
module evu_checker #(
  parameter int TW = 24,
  parameter int NF = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] tb_a,
  input logic          wr_match_a,
  input logic          wr_match_b,
  input logic          cfg_double,
  input logic          cfg_ge_a,
  input logic          link_req,
  input logic [NF-1:0] flags,
  input logic [TW-1:0] cap_a,
  input logic          pin_out,
  input logic          fire_a,
  input logic          armed_a,
  input logic          armed_b,
  input logic [TW-1:0] match_a
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (flags == '0 && pin_out == 1'b0 && !armed_a && !armed_b));

  a_r3_equal_only: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_a && !cfg_ge_a) |-> (tb_a == match_a));

  a_r4_capture_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fire_a |=> (flags[0] && cap_a == $past(tb_a)));

  a_r5_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_a && !wr_match_a) |=> !armed_a);

  a_r6_b_store_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_double && wr_match_b) |=> !armed_b);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    link_req |=> flags[4]);

  a_r11_match_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_a && !flags[2]) |=> !flags[2]);
endmodule

bind chan_event_unit evu_checker #(.TW(TW), .NF(evu_pkg::NFLAG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tb_a       (tb_a),
  .wr_match_a (wr_match_a),
  .wr_match_b (wr_match_b),
  .cfg_double (cfg_double),
  .cfg_ge_a   (cfg_ge_a),
  .link_req   (link_req),
  .flags      (flags),
  .cap_a      (cap_a),
  .pin_out    (pin_out),
  .fire_a     (fire_a),
  .armed_a    (armed_a),
  .armed_b    (armed_b),
  .match_a    (match_a)
);

// File: tb/sim_chan_event_unit.sv
module sim_chan_event_unit;
  localparam int TW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] tb_a = '0, tb_b = '0, wr_data = '0;
  logic          wr_match_a = 0, wr_match_b = 0;
  logic          cfg_double = 0, cfg_ge_a = 1, cfg_ge_b = 1;
  logic [1:0]    act_a = 0, act_b = 0, cfg_edge = 0;
  logic          pin_in = 0, link_req = 0, host_req = 0;
  logic [5:0]    flag_clr = '0;
  logic [TW-1:0] cap_a, cap_b;
  logic [5:0]    flags;
  logic          srv_req, pin_out;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  typedef struct {
    int            idx;
    logic [TW-1:0] val;
  } exp_t;
  exp_t exq[$];

  always #4 clk = ~clk;

  chan_event_unit #(.TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .tb_a(tb_a), .tb_b(tb_b), .wr_data(wr_data),
    .wr_match_a(wr_match_a), .wr_match_b(wr_match_b), .cfg_double(cfg_double),
    .cfg_ge_a(cfg_ge_a), .cfg_ge_b(cfg_ge_b), .act_a(act_a), .act_b(act_b),
    .cfg_edge(cfg_edge), .pin_in(pin_in), .link_req(link_req), .host_req(host_req),
    .flag_clr(flag_clr), .cap_a(cap_a), .cap_b(cap_b), .flags(flags),
    .srv_req(srv_req), .pin_out(pin_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int idx, input logic [TW-1:0] val);
    exp_t e;
    e.idx = idx;
    e.val = val;
    exq.push_back(e);
  endtask

  task automatic wr_a(input logic [TW-1:0] v);
    wr_data = v; wr_match_a = 1; tick(); wr_match_a = 0;
  endtask

  task automatic wr_b(input logic [TW-1:0] v);
    wr_data = v; wr_match_b = 1; tick(); wr_match_b = 0;
  endtask

  task automatic clear_all();
    flag_clr = 6'h3F; tick(); flag_clr = '0;
  endtask

  // monitor: every rising capture/match flag must match the next expected item
  logic [3:0] prev_f = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 4; i++) begin
        if (flags[i] && !prev_f[i]) begin
          logic [TW-1:0] got;
          got = (i == 0 || i == 2) ? cap_a : cap_b;
          if (exq.size() == 0) begin
            check(0, "R4/R9 unexpected flag", i, 99);
          end else begin
            exp_t e;
            e = exq.pop_front();
            check(e.idx == i, "R4/R9 flag index", i, e.idx);
            check(got == e.val, "R4/R9 capture value", got, e.val);
          end
        end
      end
    end
    prev_f = flags[3:0];
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    check(flags == 0 && cap_a == 0 && cap_b == 0, "R1 reset regs", {flags, cap_a[7:0]}, 0);
    check(pin_out == 0 && srv_req == 0, "R1 reset pins", {pin_out, srv_req}, 0);
    rst_n = 1;
    repeat (3) tick();
    check(flags == 0, "R1 disarmed after reset", flags, 0);

    // R2 greater-or-equal, stepping over, pin high
    act_a = 2'd1; tb_a = 100;
    wr_a(105);
    tb_a = 103; tick();
    check(flags[0] == 0, "R2 early no fire", flags[0], 0);
    tb_a = 106; push(0, 106); tick();
    check(pin_out == 1, "R7 drive high", pin_out, 1);
    check(cap_a == 106, "R4 capture", cap_a, 106);
    clear_all();
    tb_a = 300; tick(); tick();
    check(flags == 0, "R5 disarmed after fire", flags, 0);

    // R2 wrap and half-range boundary
    tb_a = 24'hFFFFF0; wr_a(24'hFFFFFA);
    tb_a = 24'hFFFFF5; tick();
    check(flags[0] == 0, "R2 before wrap", flags[0], 0);
    tb_a = 24'h000003; push(0, 24'h000003); tick();
    check(cap_a == 24'h3, "R2 wrapped fire", cap_a, 3);
    clear_all();
    tb_a = 24'h000010; wr_a(24'h800010); tick(); tick();
    check(flags[0] == 0, "R2 half-range no fire", flags[0], 0);
    tb_a = 24'h800010; push(0, 24'h800010); tick(); tick();
    clear_all();

    // R3 equal-only, pin low
    cfg_ge_a = 0; act_a = 2'd2; tb_a = 49;
    wr_a(50);
    tb_a = 51; tick();
    check(flags[0] == 0, "R3 skipped value", flags[0], 0);
    tb_a = 50; push(0, 50); tick();
    check(pin_out == 0, "R7 drive low", pin_out, 0);
    clear_all();

    // R6 double-action chaining
    cfg_double = 1; cfg_ge_a = 1; act_a = 2'd1; act_b = 2'd2; tb_b = 100;
    wr_b(20); tick(); tick();
    check(flags[1] == 0, "R6 B not armed by write", flags[1], 0);
    tb_a = 5; wr_a(10);
    tb_a = 12; push(0, 12); push(1, 100); tick();
    check(pin_out == 1 && flags[1] == 0, "R6 A fired first", {pin_out, flags[1]}, 2);
    tick();
    check(pin_out == 0 && cap_b == 100, "R6 B fired after A", {pin_out, cap_b[7:0]}, 100);
    clear_all();

    // R7 simultaneous fire ordering: high then toggle -> low
    cfg_double = 0; act_a = 2'd1; act_b = 2'd3; tb_a = 29; tb_b = 29;
    wr_data = 30; wr_match_a = 1; wr_match_b = 1; tick();
    wr_match_a = 0; wr_match_b = 0;
    tb_a = 30; tb_b = 30; push(0, 30); push(1, 30); tick();
    check(pin_out == 0, "R7 A then B order", pin_out, 0);

    // R8 W1C and set priority
    flag_clr = 6'b000001; tick(); flag_clr = '0;
    check(flags == 6'b000010, "R8 w1c selective", flags, 6'b000010);
    link_req = 1; flag_clr = 6'b010000; tick(); link_req = 0; flag_clr = '0;
    check(flags[4] == 1, "R8 set wins over clear", flags[4], 1);
    host_req = 1; tick(); host_req = 0;
    check(flags[5] == 1 && srv_req == 1, "R12 host flag and request", {flags[5], srv_req}, 3);
    clear_all();
    check(flags == 0 && srv_req == 0, "R12 request drops", {flags, srv_req}, 0);

    // R9 single-mode edge capture, rising only
    cfg_edge = 2'd1; tb_a = 500; pin_in = 1; push(2, 500); tick();
    check(flags[2] == 1, "R9 rising captured", flags[2], 1);
    clear_all();
    pin_in = 0; tb_a = 600; tick(); tick();
    check(flags == 0 && cap_a == 500, "R9 falling ignored", cap_a, 500);

    // R10 double-mode edge sequencing
    cfg_double = 1; cfg_edge = 2'd3;
    tb_a = 700; pin_in = 1; push(2, 700); tick();
    tb_b = 800; pin_in = 0; push(3, 800); tick();
    tb_a = 900; tb_b = 950; pin_in = 1; tick(); tick();
    check(cap_a == 700 && cap_b == 800, "R10 third edge dropped", {cap_a[11:0], cap_b[11:0]},
          {12'd700, 12'd800});
    clear_all();

    // R11 match beats edge on slot A
    cfg_double = 0; cfg_ge_a = 0; act_a = 2'd0; tb_a = 0;
    wr_a(900);
    tb_a = 900; pin_in = 0; push(0, 900); tick();
    check(flags[0] == 1 && flags[2] == 0, "R11 match priority", flags, 1);
    tick();
    check(flags[2] == 0, "R11 edge flag stays clear", flags[2], 0);

    repeat (3) tick();
    check(exq.size() == 0, "R4 all expected events seen", exq.size(), 0);
    finish_run();
  end
endmodule